// File: doc/BRIEF.md
# Transmit Jabber and Heartbeat Supervisor

This block watches the transmit-enable strobe of a 10 Mb/s transmit path. When a frame runs past the legal limit of about 24 ms, the block closes the transmit gate and drives collision high. This cutoff is latched. It persists while transmit enable stays high. It clears only after transmit enable has been low without a break for about 256 ms. If transmit enable rises during that quiet wait, the wait starts again from zero.

After every frame that ends normally, the block also produces a heartbeat on the same collision output. The heartbeat is delayed by about 1 µs and lasts about 1 µs, which is ten bit times at 10 Mb/s. It is produced only when the heartbeat enable is set and the link is not in full-duplex mode. A control input turns the whole jabber monitor off.

All intervals are computed from a clock-frequency parameter (default 25 MHz) and from interval parameters given in microseconds or nanoseconds. Tests can therefore shrink them.

Top module: `tx_supervisor`

## Requirements
- R1: After synchronous reset, `tx_gate_o` is 1 and `col_o` is 0.
- R2: The cutoff trips on a clock edge that samples `tx_en_i` high for the JAB-th consecutive time, where JAB = CLK_HZ·JAB_US/10^6. From the next sample onward, `tx_gate_o` is 0 and `col_o` is 1. After only JAB−1 high samples, both outputs are unchanged.
- R3: While the cutoff is active and `tx_en_i` remains high, `tx_gate_o` stays 0 and `col_o` stays 1.
- R4: An active cutoff clears on the edge that samples `tx_en_i` low for the UNJAB-th consecutive time, where UNJAB = CLK_HZ·UNJAB_US/10^6. After that edge, `tx_gate_o` is 1 and `col_o` is 0.
- R5: A high sample of `tx_en_i` during the quiet wait restarts the UNJAB count from zero.
- R6: While `jab_off_i` is 1, no cutoff occurs for any frame length, and an active cutoff is cleared at the next edge.
- R7: A frame ends on the first edge that samples `tx_en_i` low after it was high. Counting that edge as 1, `col_o` is high after edges DLY+1 through DLY+WID and low otherwise. Here DLY = CLK_HZ·SQE_DLY_NS/10^9 and WID = CLK_HZ·SQE_WID_NS/10^9.
- R8: No heartbeat follows a frame end at which `sqe_en_i` is 0 or `full_duplex_i` is 1.
- R9: No heartbeat follows a frame that ended while the cutoff was active. This holds even when the cutoff is cleared at that same edge.
- R10: A low sample of `tx_en_i` resets the running frame-length count. Frames of JAB−1 samples separated by a single low sample never trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| full_duplex_i | input | 1 | 1 = full-duplex link; suppresses the heartbeat |
| jab_off_i | input | 1 | 1 = jabber monitor disabled |
| sqe_en_i | input | 1 | 1 = heartbeat after each frame enabled |
| tx_gate_o | output | 1 | 1 = transmitter allowed to drive the line |
| col_o | output | 1 | Collision indication (cutoff or heartbeat) |

## Verification
An off-by-one in the frame-length counter moves the falling edge of `tx_gate_o` by one cycle when a frame is held long. The bench locates that edge cycle-exactly, and the quiet-wait counter is located the same way on recovery. A heartbeat state machine stuck in its wait or pulse phase shows up at `col_o` within DLY+WID cycles of a frame end. A wrong suppression decision shows up as a pulse that appears or disappears in that same window. The bench uses shortened intervals and sweeps every cycle around each boundary, so each such fault surfaces within a few hundred cycles.

// File: rtl/tx_sup_pkg.sv
package tx_sup_pkg;

  typedef enum logic { JS_RUN, JS_CUT } jab_state_e;

  typedef enum logic [1:0] { SQ_IDLE, SQ_WAIT, SQ_PULSE } sqe_state_e;

  // Cycles covering a span given in nanoseconds, at least one.
  function automatic int unsigned span_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/tx_jab_mon.sv
module tx_jab_mon
  import tx_sup_pkg::*;
#(
  parameter int unsigned JAB_CYC   = 600000,
  parameter int unsigned UNJAB_CYC = 6400000
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic jab_off,
  output logic cut
);

  localparam int unsigned RW = $clog2(JAB_CYC + 1);
  localparam int unsigned QW = $clog2(UNJAB_CYC + 1);

  jab_state_e    state;
  logic [RW-1:0] run_cnt;
  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst || jab_off) begin
      state     <= JS_RUN;
      run_cnt   <= '0;
      quiet_cnt <= '0;
    end else begin
      case (state)
        JS_RUN: begin
          quiet_cnt <= '0;
          if (!tx_en) begin
            run_cnt <= '0;
          end else if (run_cnt == RW'(JAB_CYC - 1)) begin
            run_cnt <= '0;
            state   <= JS_CUT;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
        default: begin
          run_cnt <= '0;
          if (tx_en) begin
            quiet_cnt <= '0;
          end else if (quiet_cnt == QW'(UNJAB_CYC - 1)) begin
            quiet_cnt <= '0;
            state     <= JS_RUN;
          end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign cut = (state == JS_CUT);

  // R3
  cut_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cut && tx_en && !jab_off) |=> cut);

  // R6
  jab_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    jab_off |=> !cut);

endmodule

// File: rtl/tx_sqe_gen.sv
module tx_sqe_gen
  import tx_sup_pkg::*;
#(
  parameter int unsigned DLY_CYC = 25,
  parameter int unsigned WID_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic cut,
  input  logic allow,
  output logic sqe
);

  localparam int unsigned MAXC = (DLY_CYC > WID_CYC) ? DLY_CYC : WID_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  sqe_state_e    state;
  logic [CW-1:0] cnt;
  logic          tx_en_d;
  logic          frame_end;

  assign frame_end = tx_en_d && !tx_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      tx_en_d <= 1'b0;
    end else begin
      tx_en_d <= tx_en;
      if (frame_end && allow && !cut) begin
        state <= SQ_WAIT;
        cnt   <= '0;
      end else begin
        case (state)
          SQ_WAIT: begin
            if (cnt == CW'(DLY_CYC - 1)) begin
              state <= SQ_PULSE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          SQ_PULSE: begin
            if (cnt == CW'(WID_CYC - 1)) begin
              state <= SQ_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= '0;
        endcase
      end
    end
  end

  assign sqe = (state == SQ_PULSE);

  // R7
  sqe_width_chk: assert property (@(posedge clk) disable iff (rst)
    sqe |-> (cnt < CW'(WID_CYC)));

  // R7
  sqe_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_WAIT) |-> (cnt < CW'(DLY_CYC)));

endmodule

// File: rtl/tx_supervisor.sv
module tx_supervisor
  import tx_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 25_000_000,
  parameter int unsigned JAB_US     = 24_000,
  parameter int unsigned UNJAB_US   = 256_000,
  parameter int unsigned SQE_DLY_NS = 1_000,
  parameter int unsigned SQE_WID_NS = 1_000
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en_i,
  input  logic full_duplex_i,
  input  logic jab_off_i,
  input  logic sqe_en_i,
  output logic tx_gate_o,
  output logic col_o
);

  localparam int unsigned JAB_CYC   = span_cycles(64'(CLK_HZ), 64'(JAB_US) * 64'd1000);
  localparam int unsigned UNJAB_CYC = span_cycles(64'(CLK_HZ), 64'(UNJAB_US) * 64'd1000);
  localparam int unsigned DLY_CYC   = span_cycles(64'(CLK_HZ), 64'(SQE_DLY_NS));
  localparam int unsigned WID_CYC   = span_cycles(64'(CLK_HZ), 64'(SQE_WID_NS));

  logic cut;
  logic sqe;
  logic allow;

  assign allow = sqe_en_i && !full_duplex_i;

  tx_jab_mon #(
    .JAB_CYC  (JAB_CYC),
    .UNJAB_CYC(UNJAB_CYC)
  ) i_jab (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en_i),
    .jab_off(jab_off_i),
    .cut    (cut)
  );

  tx_sqe_gen #(
    .DLY_CYC(DLY_CYC),
    .WID_CYC(WID_CYC)
  ) i_sqe (
    .clk  (clk),
    .rst  (rst),
    .tx_en(tx_en_i),
    .cut  (cut),
    .allow(allow),
    .sqe  (sqe)
  );

  assign tx_gate_o = !cut;
  assign col_o     = cut || sqe;

  // R2
  gate_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_gate_o) |-> $past(tx_en_i));

  // R4
  gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_gate_o) |-> (!$past(tx_en_i) || $past(jab_off_i)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (tx_gate_o && !col_o));

endmodule

// File: tb/test_tx_supervisor.sv
module test_tx_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int J = 60;
  localparam int U = 100;
  localparam int D = 8;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst, tx_en, fd, jab_off, sqe_en;
  logic gate, col;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_supervisor #(
    .CLK_HZ(10_000_000), .JAB_US(6), .UNJAB_US(10),
    .SQE_DLY_NS(800), .SQE_WID_NS(500)
  ) i_tx_supervisor (
    .clk(clk), .rst(rst), .tx_en_i(tx_en), .full_duplex_i(fd),
    .jab_off_i(jab_off), .sqe_en_i(sqe_en), .tx_gate_o(gate), .col_o(col)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Frame of len samples, then check the col profile after its end.
  task automatic frame_sqe(input int len, input bit pulse, input string req);
    tx_en = 1'b1;
    for (int k = 1; k <= len; k++) begin
      tick;
      chk(req, "col during frame", int'(col), 0);
    end
    tx_en = 1'b0;
    for (int k = 1; k <= D + W + 3; k++) begin
      tick;
      chk(req, "col after end", int'(col), int'(pulse && k >= D + 1 && k <= D + W));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tx_en = 1'b0; fd = 1'b0; jab_off = 1'b0; sqe_en = 1'b1;
    @(negedge clk); tick; tick;
    rst = 1'b0;
    // R1
    chk("R1", "gate after reset", int'(gate), 1);
    chk("R1", "col after reset", int'(col), 0);
    tick;

    // R7: heartbeat timing over several frame lengths
    frame_sqe(1, 1'b1, "R7");
    frame_sqe(3, 1'b1, "R7");
    frame_sqe(17, 1'b1, "R7");

    // R8: suppression by enable and by full duplex
    sqe_en = 1'b0;
    frame_sqe(5, 1'b0, "R8");
    sqe_en = 1'b1; fd = 1'b1;
    frame_sqe(5, 1'b0, "R8");
    fd = 1'b0;

    // R10: near-limit frames with a single-sample gap
    sqe_en = 1'b0;
    for (int f = 0; f < 2; f++) begin
      tx_en = 1'b1;
      for (int k = 1; k <= J - 1; k++) begin
        tick;
        chk("R10", "gate near limit", int'(gate), 1);
      end
      tx_en = 1'b0;
      tick;
      chk("R10", "gate in gap", int'(gate), 1);
    end
    repeat (5) tick;
    sqe_en = 1'b1;

    // R2 and R3: trip edge and hold
    tx_en = 1'b1;
    for (int k = 1; k <= J + 20; k++) begin
      tick;
      chk("R2", "gate at trip", int'(gate), int'(k < J));
      chk("R3", "col while cut", int'(col), int'(k >= J));
    end

    // R4 and R9: recovery edge, no heartbeat after jabbed frame
    tx_en = 1'b0;
    for (int k = 1; k <= U + D + W + 3; k++) begin
      tick;
      chk("R4", "gate at recovery", int'(gate), int'(k >= U));
      chk("R9", "col through recovery", int'(col), int'(k < U));
    end

    // R5: reassertion during the quiet wait restarts it
    tx_en = 1'b1;
    repeat (J) tick;
    tx_en = 1'b0;
    for (int k = 1; k <= 50; k++) begin
      tick;
      chk("R5", "gate partial wait", int'(gate), 0);
    end
    tx_en = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      tick;
      chk("R5", "gate reasserted", int'(gate), 0);
    end
    tx_en = 1'b0;
    for (int k = 1; k <= U + 2; k++) begin
      tick;
      chk("R5", "gate restarted wait", int'(gate), int'(k >= U));
    end
    repeat (D + W + 3) tick;

    // R9 and R6: cutoff cleared at the frame end, still no heartbeat
    tx_en = 1'b1;
    repeat (J + 2) tick;
    chk("R2", "gate tripped", int'(gate), 0);
    tx_en = 1'b0; jab_off = 1'b1;
    for (int k = 1; k <= D + W + 3; k++) begin
      tick;
      chk("R9", "col after cleared jab frame", int'(col), 0);
      chk("R6", "gate after disable", int'(gate), 1);
    end

    // R6: disabled monitor never trips
    sqe_en = 1'b0;
    tx_en = 1'b1;
    for (int k = 1; k <= J + 20; k++) begin
      tick;
      chk("R6", "gate disabled long frame", int'(gate), 1);
      chk("R6", "col disabled long frame", int'(col), 0);
    end
    tx_en = 1'b0;
    repeat (3) tick;
    jab_off = 1'b0;
    tick;
    chk("R1", "idle gate at end", int'(gate), 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule